// File: doc/BRIEF.md
# A/D Card Host Register and Readout Interface

This block is the host-facing register logic of a multichannel analog acquisition card. A simple synchronous bus (address, read strobe, write strobe, write data) reaches three registers. A read-only status register shows whether the card is idle. A hard-wired identification register reads back a fixed byte, and a write to it performs a soft reset. A reading register returns a 16-bit word built from the last conversion result and a busy indication.

A read of the reading register doubles as a conversion request, and it carries a channel number on its own port. The channel is latched and a conversion is started only when the card is idle. While a conversion is in flight the card is busy, and any further request is refused with a word whose top bit is set. When the converter signals completion, the magnitude, sign, common-mode overrange flag and pacing flag are captured and the card goes idle. A PROM address counter advances once per accepted request. All read data is registered and appears on the cycle after the strobe.

Top module: `adc_host_regs`

## Requirements
- R1: A read of address 1 returns 0x0012 (the identification value 18, upper byte zero) on `bus_rdata` in the cycle after the strobe.
- R2: Any write to address 1 clears busy and sets `prom_addr` to 0 at the next edge. This holds whatever the write data and even during a conversion. The soft reset takes priority over a completion arriving in the same cycle, and that completion is then discarded.
- R3: A read of address 0 returns a word whose bit 6 is 1 when idle and 0 when busy, with all other bits 0. The busy bit of the reading word is always the inverse of that bit.
- R4: A read of address 2 while idle is accepted. It returns bit 15 = 0 with bits 14..0 = {wait, overrange_n, sign, magnitude[11:0]} of the last captured result. It loads `rd_chan` into `chan_addr`, sets busy, and raises `conv_start` for exactly one cycle after the strobe. `chan_addr` changes at no other time.
- R5: A read of address 2 while busy returns 0x8000. It does not change `chan_addr`, `prom_addr` or busy, and it does not raise `conv_start`.
- R6: `conv_done` while busy captures `conv_mag` as the magnitude, `conv_neg` as the sign (1 = negative) and `pace_late` as the wait bit, and clears busy. `conv_done` while idle is ignored.
- R7: The overrange bit (bit 13) is active low. It is 0 in the word when `cm_ovr` was 1 at capture and 1 otherwise.
- R8: `prom_addr` increments by one on each accepted read and wraps from 2^PROM_W-1 to 0.
- R9: Reads of addresses other than 0, 1 and 2 return 0, and `bus_rdata` is 0 in any cycle after which no read was strobed. Writes to addresses other than 1 change nothing.
- R10: A cycle with both `bus_rd` and `bus_wr` high performs only the write; its read returns 0 and is not a request.
- R11: After reset, busy is 0 and `bus_rdata`, `chan_addr`, `prom_addr` and `conv_start` are 0. The stored result is magnitude 0, positive, no overrange, no wait (reading word 0x2000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data (only its presence matters) |
| rd_chan | input | CH_W | Channel number accompanying a read request |
| bus_rdata | output | 16 | Registered read data |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_mag | input | 12 | Converter magnitude code |
| conv_neg | input | 1 | Converter sign, 1 = negative |
| cm_ovr | input | 1 | Common-mode overrange during conversion |
| pace_late | input | 1 | Reading was not properly paced |
| conv_start | output | 1 | One-cycle conversion start pulse |
| chan_addr | output | CH_W | Latched channel address |
| prom_addr | output | PROM_W | PROM address counter |

## Verification
The bench targets a request issued while busy. A design that wrongly accepted it would move the channel, advance the PROM counter or pulse a second start. It also checks that the overrange polarity is not inverted and that a completion seen while idle does not overwrite the stored result. Further cases are a soft reset in mid-conversion, which a faulty design would leave stuck busy, and the PROM counter wrapping at its top value. Finally, it covers a read and a write in the same cycle, where a wrong priority would start a conversion or return data.

// File: rtl/adc_host_regs.sv
module adc_host_regs #(
  parameter int ADDR_W   = 4,
  parameter int CH_W     = 3,
  parameter int PROM_W   = 4,
  parameter int ID_VALUE = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [15:0]       bus_rdata,
  input  logic              conv_done,
  input  logic [11:0]       conv_mag,
  input  logic              conv_neg,
  input  logic              cm_ovr,
  input  logic              pace_late,
  output logic              conv_start,
  output logic [CH_W-1:0]   chan_addr,
  output logic [PROM_W-1:0] prom_addr
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RDG_A  = ADDR_W'(2);

  logic        busy;
  logic [14:0] result;
  logic        rd_req, accept, soft_rst, capture;
  logic [15:0] rdata_d;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign rd_req   = bus_rd & ~bus_wr;
  assign accept   = rd_req & (bus_addr == RDG_A) & ~busy;
  assign soft_rst = bus_wr & (bus_addr == ID_A);
  assign capture  = busy & conv_done & ~soft_rst;

  always_comb begin
    rdata_d = '0;
    if (rd_req) begin
      unique case (bus_addr)
        STAT_A:  rdata_d[6] = ~busy;
        ID_A:    rdata_d = 16'(ID_VALUE & 8'hFF);
        RDG_A:   rdata_d = busy ? 16'h8000 : {1'b0, result};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      result     <= 15'h2000;
      bus_rdata  <= '0;
      conv_start <= 1'b0;
      chan_addr  <= '0;
      prom_addr  <= '0;
    end else begin
      bus_rdata  <= rdata_d;
      conv_start <= accept;
      if (soft_rst) begin
        busy      <= 1'b0;
        prom_addr <= '0;
      end else if (accept) begin
        busy      <= 1'b1;
        chan_addr <= rd_chan;
        prom_addr <= prom_addr + 1'b1;
      end else if (capture) begin
        busy   <= 1'b0;
        result <= {pace_late, ~cm_ovr, conv_neg, conv_mag};
      end
    end
  end
endmodule

module adc_host_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 3,
  parameter int PROM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [15:0]       bus_rdata,
  input logic              conv_start,
  input logic [CH_W-1:0]   chan_addr,
  input logic [PROM_W-1:0] prom_addr,
  input logic              busy
);
  logic acc;
  assign acc = bus_rd && !bus_wr && bus_addr == ADDR_W'(2) && !busy;

  AST_START_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R4
  AST_CHAN_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(chan_addr)); // R4
  AST_BUSY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(2) && busy) |=> bus_rdata == 16'h8000); // R5
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(1)) |=> bus_rdata == 16'h0012); // R1
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> (!busy && prom_addr == '0)); // R2
  AST_PROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> prom_addr == PROM_W'($past(prom_addr) + 1'b1)); // R8
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(0)) |=> bus_rdata == {9'b0, !$past(busy), 6'b0}); // R3
  AST_RDWR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> bus_rdata == 16'h0000); // R10
endmodule

bind adc_host_regs adc_host_regs_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W), .PROM_W(PROM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .conv_start(conv_start), .chan_addr(chan_addr),
  .prom_addr(prom_addr), .busy(busy));

// File: tb/adc_host_regs_bench.sv
module adc_host_regs_bench;
  localparam int ADDR_W = 4, CH_W = 3, PROM_W = 4;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [CH_W-1:0] rd_chan = '0;
  logic [15:0] bus_rdata;
  logic conv_done = 0, conv_neg = 0, cm_ovr = 0, pace_late = 0;
  logic [11:0] conv_mag = '0;
  logic conv_start;
  logic [CH_W-1:0] chan_addr;
  logic [PROM_W-1:0] prom_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_host_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W), .PROM_W(PROM_W)) u_adc_host_regs (
    .clk, .rst_n, .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .rd_chan, .bus_rdata,
    .conv_done, .conv_mag, .conv_neg, .cm_ovr, .pace_late, .conv_start,
    .chan_addr, .prom_addr);

  // behavioural reference
  bit m_busy = 0;
  int m_prom = 0, m_chan = 0;
  logic [14:0] m_res = 15'h2000;
  logic [15:0] e_rdata = 0;
  bit e_start = 0;
  string e_tag = "R11", p_tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_prom = 0; m_chan = 0; m_res = 15'h2000;
      e_rdata = 0; e_start = 0; e_tag = "R11"; p_tag = "R11";
    end else begin
      bit acc;
      acc = bus_rd && !bus_wr && bus_addr == 2 && !m_busy;
      e_start = acc;
      e_rdata = 0; e_tag = "R9";
      if (bus_rd && bus_wr) e_tag = "R10";
      else if (bus_rd) begin
        if (bus_addr == 0) begin e_rdata = m_busy ? 16'h0000 : 16'h0040; e_tag = "R3"; end
        else if (bus_addr == 1) begin e_rdata = 16'd18; e_tag = "R1"; end
        else if (bus_addr == 2) begin
          if (m_busy) begin e_rdata = 16'h8000; e_tag = "R5"; end
          else begin e_rdata = {1'b0, m_res}; e_tag = m_res[13] ? "R6" : "R7"; end
        end
      end
      if (bus_wr && bus_addr == 1) begin m_busy = 0; m_prom = 0; p_tag = "R2"; end
      else if (acc) begin
        m_busy = 1; m_chan = rd_chan; m_prom = (m_prom + 1) % (1 << PROM_W); p_tag = "R8";
      end else if (m_busy && conv_done) begin
        m_busy = 0; m_res = {pace_late, !cm_ovr, conv_neg, conv_mag};
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(bus_rdata == e_rdata, e_tag, "bus_rdata", bus_rdata, e_rdata);
    chk(conv_start == e_start, "R4", "conv_start", conv_start, e_start);
    chk(chan_addr == CH_W'(m_chan), "R4", "chan_addr", chan_addr, m_chan);
    chk(prom_addr == PROM_W'(m_prom), p_tag, "prom_addr", prom_addr, m_prom);
  end

  task automatic idle_cyc(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      bus_rd = 0; bus_wr = 0; conv_done = 0;
    end
  endtask

  task automatic rd(input int a, input int ch);
    @(negedge clk); #1;
    bus_rd = 1; bus_wr = 0; conv_done = 0; bus_addr = ADDR_W'(a); rd_chan = CH_W'(ch);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_rd = 0; bus_wr = 1; conv_done = 0; bus_addr = ADDR_W'(a); bus_wdata = 16'(d);
  endtask

  task automatic done(input int mag, input bit neg, input bit ovr, input bit late);
    @(negedge clk); #1;
    bus_rd = 0; bus_wr = 0; conv_done = 1;
    conv_mag = 12'(mag); conv_neg = neg; cm_ovr = ovr; pace_late = late;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(bus_rdata == 0, "R11", "rdata in reset", bus_rdata, 0);
    chk(prom_addr == 0 && chan_addr == 0, "R11", "counters in reset", prom_addr, 0);
    chk(conv_start == 0, "R11", "start in reset", conv_start, 0);
    #1 rst_n = 1;
    rd(2, 0); idle_cyc(1);
    chk(bus_rdata == 16'h2000, "R11", "reset result word", bus_rdata, 16'h2000);
    done(0, 0, 0, 0); idle_cyc(1);
    rd(1, 0);                       // R1
    rd(0, 0);                       // R3 idle
    rd(2, 5); rd(0, 0); rd(2, 3);   // R4 accept, R3 busy, R5 refused
    done(12'hABC, 1, 0, 0);         // R6
    rd(2, 2); idle_cyc(2);
    done(12'h123, 0, 1, 1);         // R7 overrange, wait
    idle_cyc(1); done(12'hFFF, 1, 1, 1); // R6 done while idle ignored
    rd(2, 6); done(12'h7, 0, 0, 0);
    rd(7, 1); rd(15, 1);            // R9 unmapped reads
    wr(0, 16'hFFFF); wr(2, 16'hFFFF); wr(9, 16'h1234); rd(0, 0); // R9 writes ignored
    rd(2, 4); idle_cyc(1); wr(1, 16'h0055); rd(0, 0); // R2 soft reset mid-conversion
    rd(2, 1); @(negedge clk); #1;   // R2 soft reset beats done
    bus_rd = 0; bus_wr = 1; bus_addr = 1; conv_done = 1; conv_mag = 12'h555;
    idle_cyc(1); rd(2, 0); done(12'h0, 0, 0, 0); rd(2, 0);
    done(12'h1, 0, 0, 0);
    @(negedge clk); #1;             // R10 rd and wr together
    bus_rd = 1; bus_wr = 1; bus_addr = 2; conv_done = 0;
    idle_cyc(1); rd(0, 0);
    for (int i = 0; i < 20; i++) begin // R8 wrap
      rd(2, i % 8); done(i * 37, i[0], i[1], i[2]);
    end
    idle_cyc(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule